// File: doc/BRIEF.md
# DMA Address Window Decoder

This block sits between a display DMA master and the memory fabric and decides where each request address goes. Six programmable windows each describe a region of 64 KB granularity. A window carries a size mask, a base, a target ID, an attribute byte and an optional remap base. Software loads the windows through a write-only register port. Usually one window is loaded per populated memory chip-select, starting at window 0, and the unused windows are written with zero.

For every request the block compares the upper halfword of the address against all enabled windows in parallel. The lowest-numbered window that matches is selected. One cycle later the block returns a hit or miss flag together with the window index, the target ID, the attribute and the translated address. On translation the low 16 address bits always pass through unchanged.

Top module: `dma_window_map`

## Requirements
- R1: After reset every window is disabled, so every request answers with a miss.
- R2: A write with `reg_we` high selects a register with `reg_sel`: 0 is control, 1 is base, 2 is remap. A `reg_sel` of 3, or a `reg_win` of 6 or 7, changes no window.
- R3: Control bits 31:16 hold the size mask (size/64 KB minus 1), bits 15:8 the attribute, bits 7:4 the target ID and bit 0 the enable. Base and remap keep only bits 31:16; their low 16 bits are discarded.
- R4: A window matches when it is enabled and (addr[31:16] & ~mask) equals base[31:16]. A window whose enable bit is 0 never matches, whatever its other fields hold.
- R5: When several windows match, the lowest-numbered one is reported in `rsp_win`, along with its target ID and attribute.
- R6: On a hit with a nonzero remap, `rsp_addr[31:16]` is (addr[31:16] & mask) | (remap[31:16] & ~mask). With a remap of zero the address is returned unchanged. `rsp_addr[15:0]` always equals addr[15:0].
- R7: On a miss, `rsp_miss` is 1, `rsp_hit` is 0, `rsp_win`, `rsp_tid` and `rsp_attr` are 0, and `rsp_addr` equals the request address.
- R8: Results appear on the clock edge after the one that samples `req_valid`. `rsp_valid` is `req_valid` delayed by one cycle, and exactly one of hit or miss is set while it is high.
- R9: Writing zero to a window's control register disables that window at once, from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_win | input | 3 | Window index for the write |
| reg_sel | input | 2 | Register select: 0 control, 1 base, 2 remap |
| reg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | A window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_win | output | 3 | Index of the winning window |
| rsp_tid | output | 4 | Target ID of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |
| rsp_addr | output | 32 | Translated address |

## Verification
Two cases are hard to reach from the ports. One is overlapping windows, where priority and remap have to be told apart. The other is a window that is disabled but still holds nonzero fields.

The bench loads several window sets built to create these cases. One set has three windows that cover the same region with different masks and remaps. Another has a fully populated window whose enable bit is clear. The bench also writes to nonexistent windows and to the unused select code, and puts garbage in the low bits of base values. For each set it sweeps the upper halfword over a dense range and a band near the top of the address space. Every response is compared with an arithmetic model of the window rules.

// File: rtl/dma_window_map.sv
module dma_window_map #(
  parameter int NWIN = 6,
  parameter int AW   = 32,
  parameter int LOW  = 16,
  parameter int TW   = 4,
  parameter int ATW  = 8,
  localparam int WIW = $clog2(NWIN),
  localparam int HW  = AW - LOW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [WIW-1:0] reg_win,
  input  logic [1:0]     reg_sel,
  input  logic [AW-1:0]  reg_wdata,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  output logic           rsp_valid,
  output logic           rsp_hit,
  output logic           rsp_miss,
  output logic [WIW-1:0] rsp_win,
  output logic [TW-1:0]  rsp_tid,
  output logic [ATW-1:0] rsp_attr,
  output logic [AW-1:0]  rsp_addr
);

  logic [HW-1:0]  mask_q  [NWIN];
  logic [HW-1:0]  base_q  [NWIN];
  logic [HW-1:0]  remap_q [NWIN];
  logic [ATW-1:0] attr_q  [NWIN];
  logic [TW-1:0]  tid_q   [NWIN];
  logic [NWIN-1:0] en_q;

  wire wr_ok = reg_we && ({1'b0, reg_win} < (WIW+1)'(NWIN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < NWIN; i++) begin
        mask_q[i] <= '0; base_q[i] <= '0; remap_q[i] <= '0;
        attr_q[i] <= '0; tid_q[i] <= '0;
      end
    end else if (wr_ok) begin
      case (reg_sel)
        2'd0: begin
          mask_q[reg_win] <= reg_wdata[AW-1:LOW];
          attr_q[reg_win] <= reg_wdata[LOW-1 -: ATW];
          tid_q[reg_win]  <= reg_wdata[4 +: TW];
          en_q[reg_win]   <= reg_wdata[0];
        end
        2'd1: base_q[reg_win]  <= reg_wdata[AW-1:LOW];
        2'd2: remap_q[reg_win] <= reg_wdata[AW-1:LOW];
        default: ;
      endcase
    end
  end

  wire [HW-1:0] a_hi = req_addr[AW-1:LOW];
  logic [NWIN-1:0] match;

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    assign match[g] = en_q[g] && ((a_hi & ~mask_q[g]) == base_q[g]);
  end

  logic [WIW-1:0] pick;
  always_comb begin
    pick = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (match[i]) pick = WIW'(i);
  end

  wire          any   = |match;
  wire [HW-1:0] rm    = remap_q[pick];
  wire [HW-1:0] o_hi  = (rm == '0) ? a_hi : ((a_hi & mask_q[pick]) | (rm & ~mask_q[pick]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0;
      rsp_win <= '0; rsp_tid <= '0; rsp_attr <= '0; rsp_addr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any;
      rsp_miss  <= req_valid && !any;
      rsp_win   <= any ? pick : '0;
      rsp_tid   <= any ? tid_q[pick] : '0;
      rsp_attr  <= any ? attr_q[pick] : '0;
      rsp_addr  <= any ? {o_hi, req_addr[LOW-1:0]} : req_addr;
    end
  end

  p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));
  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(rsp_valid || rsp_hit || rsp_miss));
  p_low_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_addr[LOW-1:0] == $past(req_addr[LOW-1:0]));
  p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_miss |-> (rsp_win == '0 && rsp_tid == '0 && rsp_attr == '0
                                 && rsp_addr == $past(req_addr))));
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> en_q == '0);

endmodule

// File: tb/sim_dma_window_map.sv
module sim_dma_window_map;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_win = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic req_valid = 0;
  logic [31:0] req_addr = 0;
  logic rsp_valid, rsp_hit, rsp_miss;
  logic [2:0] rsp_win;
  logic [3:0] rsp_tid;
  logic [7:0] rsp_attr;
  logic [31:0] rsp_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_ctrl [6];
  logic [31:0] m_base [6];
  logic [31:0] m_remap [6];

  always #(CLK_NS/2) clk = ~clk;

  dma_window_map u0 (.clk, .rst_n, .reg_we, .reg_win, .reg_sel, .reg_wdata,
    .req_valid, .req_addr, .rsp_valid, .rsp_hit, .rsp_miss, .rsp_win,
    .rsp_tid, .rsp_attr, .rsp_addr);

  task automatic wr(input int w, input int s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_win = 3'(w); reg_sel = 2'(s); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (w < 6) begin
      if (s == 0) m_ctrl[w] = d;
      else if (s == 1) m_base[w] = d;
      else if (s == 2) m_remap[w] = d;
    end
  endtask

  task automatic req(input logic [31:0] a, input string tag);
    bit h; int w; logic [3:0] t; logic [7:0] at; logic [31:0] o;
    logic [15:0] m, hi, rm;
    h = 0; w = 0; t = 0; at = 0; o = a; hi = a[31:16];
    for (int i = 5; i >= 0; i--) begin
      m = m_ctrl[i][31:16];
      if (m_ctrl[i][0] && ((hi & ~m) == m_base[i][31:16])) begin
        h = 1; w = i; t = m_ctrl[i][7:4]; at = m_ctrl[i][15:8];
        rm = m_remap[i][31:16];
        o = (rm == 0) ? a : {(hi & m) | (rm & ~m), a[15:0]};
      end
    end
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    n_chk++;
    if (rsp_valid !== 1 || rsp_hit !== h || rsp_miss !== !h || rsp_win !== 3'(w) ||
        rsp_tid !== t || rsp_attr !== at || rsp_addr !== o) begin
      n_bad++;
      $display("FAIL %s a=%h got v%0b h%0b m%0b w%0d t%h at%h o%h exp h%0b w%0d t%h at%h o%h",
        tag, a, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_tid, rsp_attr, rsp_addr,
        h, w, t, at, o);
    end
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 72; k++) req({16'(k), 16'(k * 16'h1357) ^ 16'hA5A5}, tag);
    for (int k = 0; k < 8; k++) req({16'hFFF8 + 16'(k), 16'(k * 77)}, tag);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 6; i++) begin wr(i, 0, 0); wr(i, 1, 0); wr(i, 2, 0); end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin m_ctrl[i] = 0; m_base[i] = 0; m_remap[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0) begin
      n_bad++; $display("FAIL R8 idle outputs v%0b h%0b m%0b exp 0 0 0", rsp_valid, rsp_hit, rsp_miss);
    end
    sweep("R1 reset all miss");

    // chip-select style: two 1 MB windows back to back (R3 R4 R6 R7)
    wr(0, 0, 32'h000F_0E01); wr(0, 1, 32'h0000_0000);
    wr(1, 0, 32'h000F_0D11); wr(1, 1, 32'h0010_0000);
    sweep("R3/R4 two windows");

    // overlapping windows with remap; base low bits dropped (R3 R5 R6)
    clear_all();
    wr(2, 0, 32'h000F_5523); wr(2, 1, 32'h0020_FFFF); wr(2, 2, 32'h1230_0000);
    wr(3, 0, 32'h003F_6633); wr(3, 1, 32'h0000_1234);
    wr(5, 0, 32'h0007_7751); wr(5, 1, 32'h0030_0000); wr(5, 2, 32'h8000_0000);
    sweep("R5/R6 overlap priority remap");

    // ignored writes: bad index and select 3 (R2)
    wr(6, 0, 32'hFFFF_FF01); wr(7, 1, 32'h0000_0000); wr(4, 3, 32'hFFFF_FFFF);
    wr(0, 3, 32'h0000_0001);
    sweep("R2 ignored writes");

    // disabled but populated window; single 64 KB window near top (R4)
    clear_all();
    wr(4, 0, 32'hFFFF_FFF0); wr(4, 2, 32'h4444_0000);
    wr(5, 0, 32'h0000_2291); wr(5, 1, 32'hFFFB_0000); wr(5, 2, 32'hABCD_0000);
    wr(1, 0, 32'h0000_3321); wr(1, 1, 32'h0015_0000);
    sweep("R4 disabled window");

    // zero control disables (R9)
    wr(5, 0, 32'h0); wr(1, 0, 32'h0);
    sweep("R9 zeroed windows miss");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule